// File: doc/BRIEF.md
# Dual Page Buffer Load Sequencer

This block fills one of two 256-byte staging buffers from a multi-cycle write sequence on a simple synchronous bus. A load command byte is followed by two count cycles. These give the number of items to load, one byte each. Then come the data items. The first data cycle also carries the start address, and the address advances by one per item. In byte mode each item is one byte. In word mode each item is a 16-bit word, and the buffer is seen as 128 words. A second command swaps which buffer is active. The active buffer is the one that loads take and that reads return.

In byte mode the host picks which count half comes first through address bit 0 of the first count cycle. The second count cycle always supplies the other half. A nonzero high count byte would reach past one buffer, so the block raises an error flag and drops the sequence. When no sequence is in progress, a read strobe returns the active buffer entry at the given address one cycle later.

Top module: `dual_pbuf_loader`

## Requirements
- R1: After reset both buffers hold zero, buffer 0 is active, the sequencer is idle, `err` is 0 and `rd_data` is 0.
- R2: A write with data[7:0]=E0h starts a load. Two count cycles and then count+1 data cycles follow. Item i is written at start address + i, where the start address is `addr` on the first data cycle. A count of 00h loads exactly one item.
- R3: In byte mode, addr[0] on the first count cycle selects what that cycle carries: 0 means the low count byte, 1 means the high count byte. The second count cycle carries the other half, whatever its addr[0] is.
- R4: If the high count byte is not 00h, `err` goes to 1 one cycle after the second count cycle. The sequencer returns to idle and no buffer entry changes.
- R5: In word mode (byte_mode=0), the first count cycle is the low byte and the second is the high byte. Only data[7:0] is used on count and command cycles. Each data item writes data[7:0] to byte 2w and data[15:8] to byte 2w+1, where w is the word index.
- R6: The load address wraps modulo 256 in byte mode and modulo 128 in word mode.
- R7: A write with data[7:0]=72h while idle toggles the active buffer. Later loads and reads use the new buffer, and the other buffer keeps its contents.
- R8: Any other command byte while idle leaves the sequencer idle. It changes no buffer entry, does not swap buffers and does not change `err`.
- R9: A read strobe while idle loads `rd_data` at the next clock edge. In byte mode the value is {00h, byte[addr]}. In word mode it is {byte[2w+1], byte[2w]} with w=addr[6:0]. A read strobe while a sequence is in progress leaves `rd_data` unchanged.
- R10: `err` clears on the next E0h or 72h command.
- R11: A read and a swap command in the same cycle return data from the buffer that was active before the swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one bus cycle per clock |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte address (byte mode) or word address in bits 6:0 (word mode) |
| wdata | input | 16 | Write data / command / count |
| byte_mode | input | 1 | 1 = byte-wide items, 0 = 16-bit items |
| rd_data | output | 16 | Registered read data |
| err | output | 1 | Set by a nonzero high count |

## Verification
A read strobe and a swap command can fall in the same cycle, because both are accepted while the sequencer is idle. The bench provokes this by raising `rd_en` together with a 72h write after it has filled the two buffers differently. It expects the returned data to come from the old buffer, and it expects a following read to come from the new one. A read strobe that arrives during a load data cycle is also driven, and `rd_data` must hold its previous value.

// File: rtl/pbl_pkg.sv
// Shared types and constants for the dual page buffer loader.
// Assumes a single clock domain and byte-granular storage.
package pbl_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_CNT_A,
        S_CNT_B,
        S_LOAD_FIRST,
        S_LOAD_MORE
    } seq_state_t;

    localparam logic [7:0] CMD_LOAD = 8'hE0;
    localparam logic [7:0] CMD_SWAP = 8'h72;
    localparam int         NBANK    = 2;
    localparam int         CNT_W    = 8;
endpackage

// File: rtl/pbl_seq_ctrl.sv
// Command/count/data sequencer. Decodes the load and swap commands,
// assembles the item count from two cycles and produces a write index
// per data item. Assumes byte_mode is stable during a sequence.
module pbl_seq_ctrl
    import pbl_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             byte_mode,
    input  logic [IDX_W-1:0] addr,
    input  logic [15:0]      wdata,
    output logic             wr_go,
    output logic [IDX_W-1:0] wr_idx,
    output logic             bank_sel,
    output logic             err_flag,
    output logic             seq_idle
);
    localparam logic [IDX_W-1:0] WORD_MASK = {1'b0, {(IDX_W-1){1'b1}}};

    seq_state_t       state;
    logic             first_hi;
    logic [CNT_W-1:0] held, cnt, left;
    logic [IDX_W-1:0] ptr;
    logic [7:0]       cmd;
    logic [CNT_W-1:0] cnt_lo, cnt_hi;

    assign cmd = wdata[7:0];

    // Limit an index to the buffer size of the current mode.
    function automatic logic [IDX_W-1:0] fit(input logic bm, input logic [IDX_W-1:0] x);
        return bm ? x : (x & WORD_MASK);
    endfunction

    // Pair the held first count byte with the current one.
    always_comb begin
        cnt_lo = first_hi ? cmd : held;
        cnt_hi = first_hi ? held : cmd;
    end

    // Sequencer state, count capture, pointer, active bank and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            first_hi <= 1'b0;
            held     <= '0;
            cnt      <= '0;
            left     <= '0;
            ptr      <= '0;
            bank_sel <= 1'b0;
            err_flag <= 1'b0;
        end else if (wr_en) begin
            case (state)
                S_IDLE: begin
                    if (cmd == CMD_LOAD) begin
                        state    <= S_CNT_A;
                        err_flag <= 1'b0;
                    end else if (cmd == CMD_SWAP) begin
                        bank_sel <= ~bank_sel;
                        err_flag <= 1'b0;
                    end
                end
                S_CNT_A: begin
                    first_hi <= byte_mode & addr[0];
                    held     <= cmd;
                    state    <= S_CNT_B;
                end
                S_CNT_B: begin
                    if (cnt_hi != '0) begin
                        err_flag <= 1'b1;
                        state    <= S_IDLE;
                    end else begin
                        cnt   <= cnt_lo;
                        state <= S_LOAD_FIRST;
                    end
                end
                S_LOAD_FIRST: begin
                    ptr  <= fit(byte_mode, fit(byte_mode, addr) + 1'b1);
                    left <= cnt;
                    if (cnt == '0) state <= S_IDLE;
                    else           state <= S_LOAD_MORE;
                end
                S_LOAD_MORE: begin
                    ptr  <= fit(byte_mode, ptr + 1'b1);
                    left <= left - 1'b1;
                    if (left == CNT_W'(1)) state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Write strobe and index for the storage.
    always_comb begin
        wr_go    = wr_en && (state == S_LOAD_FIRST || state == S_LOAD_MORE);
        wr_idx   = (state == S_LOAD_FIRST) ? fit(byte_mode, addr) : ptr;
        seq_idle = (state == S_IDLE);
    end

    // R4: the error flag only rises straight after a second count cycle
    p_err_from_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(state == S_CNT_B && wr_en));

    // R7/R8: the bank only changes on a swap command taken while idle
    p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && state == S_IDLE && cmd == CMD_SWAP) |=> $stable(bank_sel));

    // R10: a valid command clears the error flag
    p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state == S_IDLE && (cmd == CMD_LOAD || cmd == CMD_SWAP)) |=> !err_flag);

    // R2: the last data item returns the sequencer to idle
    p_load_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state == S_LOAD_MORE && left == CNT_W'(1)) |=> state == S_IDLE);

    // R6: word-mode writes stay inside 128 words
    p_word_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !byte_mode) |-> (wr_idx[IDX_W-1] == 1'b0));
endmodule

// File: rtl/pbl_buf_store.sv
// Two banks of byte storage. Writes one byte (byte mode) or a byte pair
// (word mode) into the selected bank; registers read data from the bank
// that is active in the read cycle. Assumes one write per cycle at most.
module pbl_buf_store
    import pbl_pkg::*;
#(
    parameter int BUF_BYTES = 256,
    parameter int IDX_W     = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_mode,
    input  logic             bank_sel,
    input  logic             wr_go,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [15:0]      wdata,
    input  logic             rd_go,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [15:0]      rd_data
);
    logic [15:0] bank_word [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [7:0]       mem [BUF_BYTES];
        logic [IDX_W-1:0] wr_lo, rd_lo;

        assign wr_lo = {wr_idx[IDX_W-2:0], 1'b0};
        assign rd_lo = {rd_idx[IDX_W-2:0], 1'b0};

        // Clear on reset, then store bytes addressed to this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < BUF_BYTES; i++) mem[i] <= 8'h00;
            end else if (wr_go && bank_sel == 1'(g)) begin
                if (byte_mode) begin
                    mem[wr_idx] <= wdata[7:0];
                end else begin
                    mem[wr_lo]         <= wdata[7:0];
                    mem[wr_lo | 1'b1]  <= wdata[15:8];
                end
            end
        end

        // Present this bank's entry in the shape of the current mode.
        assign bank_word[g] = byte_mode ? {8'h00, mem[rd_idx]}
                                        : {mem[rd_lo | 1'b1], mem[rd_lo]};
    end

    // Read data register, loaded only on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= 16'h0000;
        else if (rd_go) rd_data <= bank_word[bank_sel];
    end
endmodule

// File: rtl/dual_pbuf_loader.sv
// Top of the dual page buffer loader: joins the sequencer and the two-bank
// storage. Reads are accepted only while no sequence is in progress.
module dual_pbuf_loader
    import pbl_pkg::*;
#(
    parameter int BUF_BYTES = 256,
    localparam int IDX_W    = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] addr,
    input  logic [15:0]      wdata,
    input  logic             byte_mode,
    output logic [15:0]      rd_data,
    output logic             err
);
    logic             wr_go, bank_sel, seq_idle, rd_go;
    logic [IDX_W-1:0] wr_idx;

    assign rd_go = rd_en && seq_idle;

    pbl_seq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .byte_mode(byte_mode),
        .addr(addr), .wdata(wdata), .wr_go(wr_go), .wr_idx(wr_idx),
        .bank_sel(bank_sel), .err_flag(err), .seq_idle(seq_idle)
    );

    pbl_buf_store #(.BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .bank_sel(bank_sel),
        .wr_go(wr_go), .wr_idx(wr_idx), .wdata(wdata),
        .rd_go(rd_go), .rd_idx(addr), .rd_data(rd_data)
    );

    // R9: a read strobe during a sequence leaves the read data alone
    p_busy_read_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !seq_idle) |=> $stable(rd_data));
endmodule

// File: tb/sim_dual_pbuf_loader.sv
module sim_dual_pbuf_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, byte_mode = 1'b1;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rd_data;
    logic        err;

    int total = 0, bad = 0;
    bit done = 0;

    logic [7:0] bm [2][256];
    bit   act = 0;
    bit   merr = 0;

    always #4 clk = ~clk;

    dual_pbuf_loader u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .byte_mode(byte_mode), .rd_data(rd_data), .err(err));

    function automatic logic [15:0] exp_rd(input bit m, input logic [7:0] a);
        if (m) return {8'h00, bm[act][a]};
        return {bm[act][{a[6:0], 1'b1}], bm[act][{a[6:0], 1'b0}]};
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a);
        logic [15:0] e;
        e = exp_rd(byte_mode, a);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
        chk(tag, rd_data, e);
    endtask

    task automatic swap();
        wr($urandom, {8'($urandom), 8'h72});
        act = ~act; merr = 0;
    endtask

    // Full load: ord selects high-count-first in byte mode.
    task automatic load(input bit ord, input logic [7:0] lo, input logic [7:0] hi,
                        input logic [7:0] start, input logic [7:0] junk);
        wr(8'h00, {junk, 8'hE0});
        merr = 0;
        if (ord) begin wr(8'h01, {junk, hi}); wr(8'h00, {junk, lo}); end
        else     begin wr(8'h00, {junk, lo}); wr(8'h01, {junk, hi}); end
        if (hi != 0) begin merr = 1; return; end
        for (int i = 0; i <= int'(lo); i++) begin
            logic [15:0] d;
            logic [7:0]  ix;
            d = 16'($urandom);
            ix = byte_mode ? 8'(int'(start) + i) : {1'b0, 7'(int'(start[6:0]) + i)};
            wr(i == 0 ? start : 8'($urandom), d);
            if (byte_mode) bm[act][ix] = d[7:0];
            else begin
                bm[act][{ix[6:0], 1'b0}] = d[7:0];
                bm[act][{ix[6:0], 1'b1}] = d[15:8];
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int b = 0; b < 2; b++) for (int i = 0; i < 256; i++) bm[b][i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 err", {15'b0, err}, 16'h0);
        chk("R1 rd_data", rd_data, 16'h0);
        rd_chk("R1 buf0 zero", 8'h5A);
        // R2 single item with count 00h, neighbour untouched
        load(0, 8'h00, 8'h00, 8'h10, 8'h00);
        rd_chk("R2 one item", 8'h10);
        rd_chk("R2 next untouched", 8'h11);
        // R3 high count first
        load(1, 8'h03, 8'h00, 8'h20, 8'h00);
        rd_chk("R3 item0", 8'h20);
        rd_chk("R3 item3", 8'h23);
        rd_chk("R3 beyond", 8'h24);
        // R4 nonzero high count
        load(1, 8'h05, 8'h01, 8'h40, 8'h00);
        chk("R4 err", {15'b0, err}, 16'h1);
        wr(8'h40, 16'h00EE); // would be data if the sequence lived; reads as unknown cmd
        rd_chk("R4 no write", 8'h40);
        // R8 unknown command keeps err and writes nothing
        wr(8'h41, 16'h00A5);
        chk("R8 err kept", {15'b0, err}, 16'h1);
        rd_chk("R8 no write", 8'h41);
        // R10 err clears on load command
        load(0, 8'h01, 8'h00, 8'hFE, 8'h00);
        chk("R10 err clear", {15'b0, err}, 16'h0);
        // R6 byte wrap: FE FF 00 01 (two items here) then wider
        load(0, 8'h03, 8'h00, 8'hFE, 8'h00);
        rd_chk("R6 byte wrap 00", 8'h00);
        rd_chk("R6 byte wrap 01", 8'h01);
        // R5 word mode: upper bits junk on count cycles
        byte_mode = 1'b0;
        load(0, 8'h02, 8'h00, 8'h7F, 8'hC3);
        chk("R5 no err", {15'b0, err}, 16'h0);
        rd_chk("R5 word 7F", 8'h7F);
        rd_chk("R6 word wrap 00", 8'h00);
        rd_chk("R6 word wrap 01", 8'h01);
        // R7 swap: buffer 1 empty
        swap();
        rd_chk("R7 buf1 zero", 8'h7F);
        load(0, 8'h00, 8'h00, 8'h05, 8'h00);
        rd_chk("R7 buf1 write", 8'h05);
        // R11 read and swap in the same cycle
        begin
            logic [15:0] e;
            e = exp_rd(0, 8'h05);
            @(negedge clk); wr_en = 1; rd_en = 1; addr = 8'h05; wdata = 16'h0072;
            @(negedge clk); wr_en = 0; rd_en = 0;
            act = ~act;
            chk("R11 old buffer", rd_data, e);
            rd_chk("R11 new buffer", 8'h05);
        end
        // R9 read during load ignored
        begin
            logic [15:0] prev;
            prev = rd_data;
            wr(8'h00, 16'h00E0); wr(8'h00, 16'h0000); wr(8'h01, 16'h0000);
            @(negedge clk); wr_en = 1; rd_en = 1; addr = 8'h7F; wdata = 16'h1234;
            @(negedge clk); wr_en = 0; rd_en = 0;
            bm[act][8'hFE] = 8'h34; bm[act][8'hFF] = 8'h12;
            chk("R9 busy read hold", rd_data, prev);
            rd_chk("R9 load landed", 8'h7F);
        end
        // Random mix
        for (int it = 0; it < 60; it++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k == 0) swap();
            else if (k == 1) begin
                load($urandom_range(0, 1), 8'($urandom), 8'($urandom_range(1, 255)), 8'h00, 8'($urandom));
                chk("R4 random err", {15'b0, err}, 16'h1);
            end else begin
                byte_mode = $urandom_range(0, 1);
                load(byte_mode ? $urandom_range(0, 1) : 0, 8'($urandom_range(0, 24)), 8'h00,
                     8'($urandom), byte_mode ? 8'h00 : 8'($urandom));
            end
            for (int r = 0; r < 3; r++) rd_chk("R2 random read", 8'($urandom));
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule